// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Register

This block is the command register pair through which software on one processor asks for an interrupt message to be sent to other processors. Software sees three 32-bit words on a simple word-indexed register port: a high command word, a low command word, and a status word. The high word holds the destination ID. Writing the low word is the trigger. On that write the block captures the low-word fields and resolves the destination, then presents one message on a valid/ready message port.

The message carries the vector, delivery mode, destination mode, level-assert flag, destination shorthand and a resolved destination. When the shorthand field is non-zero it replaces the explicit destination ID. It can address the sender itself, every processor, or every processor except the sender. A read-only busy bit in the low word stays set from the trigger until the port accepts the message. A trigger that arrives while busy is dropped and leaves a sticky error flag for software to inspect and clear.

Top module: `ipi_cmd`

## Requirements
- R1: After reset, msg_valid is 0, bus_rdata is 0, and reads of the low, high and status words return 0.
- R2: A write to the high word (index 1) stores bits 31:24 as the destination ID, reads back with all other bits 0, and never starts a message.
- R3: A write to the low word (index 0) while idle raises msg_valid on the next cycle. The message carries low-word bits 7:0 as vector, 10:8 as delivery mode, bit 11 as destination mode (1 = logical), bit 14 as level-assert and bits 19:18 as shorthand.
- R4: Low-word bit 12 reads 1 from the trigger until the cycle in which msg_valid and msg_ready are both high. msg_valid is 0 in the cycle after that handshake.
- R5: While msg_valid is high and msg_ready is low, every message field holds its value.
- R6: A low-word write while busy is ignored: no new message, and the stored low word is unchanged. It sets status bit 0, which stays set until software writes 1 to status bit 0 (status word, index 2).
- R7: Shorthand 00 sends to the high-word destination ID with msg_bcast = 0 and msg_skip_self = 0.
- R8: Shorthand 01 sends to self_id only, with msg_bcast = 0.
- R9: Shorthand 10 gives msg_bcast = 1 and msg_skip_self = 0. Shorthand 11 gives msg_bcast = 1 and msg_skip_self = 1. For both, msg_dest is all ones and the high-word ID is ignored.
- R10: Low value 0x00004500 launches mode 101 (INIT) with assert set and vector 0. Low value 0x00004608 launches mode 110 (startup) with the page number 0x08 as vector.
- R11: A low-word read returns only the stored fields of R3 plus the busy bit. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| self_id | input | ID_W | ID of the processor owning this register |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word index: 0 low, 1 high, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after bus_re |
| msg_valid | output | 1 | Message present on the port |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Vector or start page |
| msg_mode | output | 3 | Delivery mode |
| msg_logical | output | 1 | Destination mode, 1 = logical |
| msg_assert | output | 1 | Level-assert flag |
| msg_shorthand | output | 2 | Destination shorthand |
| msg_dest | output | ID_W | Resolved destination |
| msg_bcast | output | 1 | Message goes to all processors |
| msg_skip_self | output | 1 | Broadcast excludes the sender |

## Verification
The bench builds the block with its defaults: ADDR_W = 4, ID_W = 8, and the low, high and status words at indices 0, 1 and 2. With an 8-bit ID, the all-ones broadcast destination 0xFF can be told apart from the explicit ID 0xAB and from self_id 0x05. This shows each shorthand override at the port. Holding msg_ready low across several cycles exposes the busy window. Within that window the bench checks the rejected trigger, the sticky error and the stability of a held message.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int CMD_W     = 32;
  localparam int VEC_LSB   = 0;
  localparam int MODE_LSB  = 8;
  localparam int LOGIC_BIT = 11;
  localparam int BUSY_BIT  = 12;
  localparam int ASRT_BIT  = 14;
  localparam int SH_LSB    = 18;

  typedef enum logic [1:0] {
    SH_EXPLICIT = 2'b00,
    SH_SELF     = 2'b01,
    SH_ALL      = 2'b10,
    SH_OTHERS   = 2'b11
  } shorthand_e;

  typedef struct packed {
    logic [1:0] sh;
    logic       asrt;
    logic       logical;
    logic [2:0] mode;
    logic [7:0] vec;
  } low_t;

  function automatic low_t unpack_low(input logic [CMD_W-1:0] w);
    low_t r;
    r.vec     = w[VEC_LSB +: 8];
    r.mode    = w[MODE_LSB +: 3];
    r.logical = w[LOGIC_BIT];
    r.asrt    = w[ASRT_BIT];
    r.sh      = w[SH_LSB +: 2];
    return r;
  endfunction

  function automatic logic [CMD_W-1:0] pack_low(input low_t f, input logic busy);
    logic [CMD_W-1:0] w;
    w = '0;
    w[VEC_LSB +: 8]  = f.vec;
    w[MODE_LSB +: 3] = f.mode;
    w[LOGIC_BIT]     = f.logical;
    w[BUSY_BIT]      = busy;
    w[ASRT_BIT]      = f.asrt;
    w[SH_LSB +: 2]   = f.sh;
    return w;
  endfunction
endpackage

// File: rtl/ipi_route.sv
module ipi_route
  import ipi_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic [1:0]      sh,
  input  logic [ID_W-1:0] hi_dest,
  input  logic [ID_W-1:0] self_id,
  output logic [ID_W-1:0] dest,
  output logic            bcast,
  output logic            skip_self
);
  always_comb begin
    dest      = hi_dest;
    bcast     = 1'b0;
    skip_self = 1'b0;
    case (shorthand_e'(sh))
      SH_EXPLICIT: dest = hi_dest;
      SH_SELF:     dest = self_id;
      SH_ALL: begin
        dest  = '1;
        bcast = 1'b1;
      end
      default: begin
        dest      = '1;
        bcast     = 1'b1;
        skip_self = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ipi_regs.sv
module ipi_regs
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int ID_W   = 8,
  parameter int LO_IDX = 0,
  parameter int HI_IDX = 1,
  parameter int ST_IDX = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CMD_W-1:0]  bus_wdata,
  input  logic              accept,
  input  logic              busy,
  input  logic              err,
  output logic              lo_wr,
  output logic              err_clr,
  output logic [ID_W-1:0]   hi_dest,
  output logic [CMD_W-1:0]  bus_rdata
);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(LO_IDX);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(HI_IDX);
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(ST_IDX);

  low_t            lo_q;
  logic [ID_W-1:0] hi_q;
  logic [CMD_W-1:0] rd_mux;

  assign lo_wr   = bus_we && (bus_addr == A_LO);
  assign err_clr = bus_we && (bus_addr == A_ST) && bus_wdata[0];
  assign hi_dest = hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (accept)
        lo_q <= unpack_low(bus_wdata);
      if (bus_we && (bus_addr == A_HI))
        hi_q <= bus_wdata[CMD_W-1 -: ID_W];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_LO)
      rd_mux = pack_low(lo_q, busy);
    else if (bus_addr == A_HI)
      rd_mux[CMD_W-1 -: ID_W] = hi_q;
    else if (bus_addr == A_ST)
      rd_mux[0] = err;
  end

  always_ff @(posedge clk) begin
    if (rst)
      bus_rdata <= '0;
    else if (bus_re)
      bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/ipi_launch.sv
module ipi_launch
  import ipi_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lo_wr,
  input  low_t            fields,
  input  logic [ID_W-1:0] r_dest,
  input  logic            r_bcast,
  input  logic            r_skip,
  input  logic            err_clr,
  input  logic            msg_ready,
  output logic            accept,
  output logic            busy,
  output logic            err,
  output logic            msg_valid,
  output logic [7:0]      msg_vector,
  output logic [2:0]      msg_mode,
  output logic            msg_logical,
  output logic            msg_assert,
  output logic [1:0]      msg_shorthand,
  output logic [ID_W-1:0] msg_dest,
  output logic            msg_bcast,
  output logic            msg_skip_self
);
  assign busy   = msg_valid;
  assign accept = lo_wr && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
    end else if (accept) begin
      msg_valid <= 1'b1;
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_vector    <= '0;
      msg_mode      <= '0;
      msg_logical   <= 1'b0;
      msg_assert    <= 1'b0;
      msg_shorthand <= '0;
      msg_dest      <= '0;
      msg_bcast     <= 1'b0;
      msg_skip_self <= 1'b0;
    end else if (accept) begin
      msg_vector    <= fields.vec;
      msg_mode      <= fields.mode;
      msg_logical   <= fields.logical;
      msg_assert    <= fields.asrt;
      msg_shorthand <= fields.sh;
      msg_dest      <= r_dest;
      msg_bcast     <= r_bcast;
      msg_skip_self <= r_skip;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      err <= 1'b0;
    else if (lo_wr && busy)
      err <= 1'b1;
    else if (err_clr)
      err <= 1'b0;
  end
endmodule

// File: rtl/ipi_cmd.sv
module ipi_cmd
  import ipi_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int ID_W   = 8,
  parameter int LO_IDX = 0,
  parameter int HI_IDX = 1,
  parameter int ST_IDX = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   self_id,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_mode,
  output logic              msg_logical,
  output logic              msg_assert,
  output logic [1:0]        msg_shorthand,
  output logic [ID_W-1:0]   msg_dest,
  output logic              msg_bcast,
  output logic              msg_skip_self
);
  logic            lo_wr, err_clr, accept, busy, err_q;
  logic [ID_W-1:0] hi_dest, r_dest;
  logic            r_bcast, r_skip;
  low_t            fields;

  assign fields = unpack_low(bus_wdata);

  ipi_regs #(
    .ADDR_W(ADDR_W), .ID_W(ID_W),
    .LO_IDX(LO_IDX), .HI_IDX(HI_IDX), .ST_IDX(ST_IDX)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .accept(accept),
    .busy(busy), .err(err_q), .lo_wr(lo_wr), .err_clr(err_clr),
    .hi_dest(hi_dest), .bus_rdata(bus_rdata)
  );

  ipi_route #(.ID_W(ID_W)) u_route (
    .sh(fields.sh), .hi_dest(hi_dest), .self_id(self_id),
    .dest(r_dest), .bcast(r_bcast), .skip_self(r_skip)
  );

  ipi_launch #(.ID_W(ID_W)) u_launch (
    .clk(clk), .rst(rst), .lo_wr(lo_wr), .fields(fields),
    .r_dest(r_dest), .r_bcast(r_bcast), .r_skip(r_skip),
    .err_clr(err_clr), .msg_ready(msg_ready), .accept(accept),
    .busy(busy), .err(err_q), .msg_valid(msg_valid),
    .msg_vector(msg_vector), .msg_mode(msg_mode),
    .msg_logical(msg_logical), .msg_assert(msg_assert),
    .msg_shorthand(msg_shorthand), .msg_dest(msg_dest),
    .msg_bcast(msg_bcast), .msg_skip_self(msg_skip_self)
  );
endmodule

// File: rtl/ipi_cmd_chk.sv
module ipi_cmd_chk #(
  parameter int ADDR_W = 4,
  parameter int ID_W   = 8,
  parameter int LO_IDX = 0,
  parameter int HI_IDX = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [7:0]        msg_vector,
  input logic [2:0]        msg_mode,
  input logic [ID_W-1:0]   msg_dest,
  input logic              msg_bcast,
  input logic              msg_skip_self,
  input logic              err
);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(LO_IDX);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(HI_IDX);

  assert_high_no_send_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_HI && !msg_valid) |=> !msg_valid);

  assert_trigger_launch_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_LO && !msg_valid) |=> msg_valid);

  assert_busy_until_accept_R4: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> msg_valid);

  assert_drop_after_accept_R4: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_ready) |=> !msg_valid);

  assert_hold_fields_R5: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> ($stable(msg_vector) && $stable(msg_mode)
      && $stable(msg_dest) && $stable(msg_bcast)));

  assert_busy_write_err_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_LO && msg_valid) |=> err);

  assert_skip_implies_bcast_R9: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_skip_self) |-> (msg_bcast && msg_dest == '1));
endmodule

bind ipi_cmd ipi_cmd_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .LO_IDX(LO_IDX), .HI_IDX(HI_IDX)
) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
  .msg_mode(msg_mode), .msg_dest(msg_dest), .msg_bcast(msg_bcast),
  .msg_skip_self(msg_skip_self), .err(err_q)
);

// File: tb/tb_ipi_cmd.sv
module tb_ipi_cmd;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int ID_W   = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic [ID_W-1:0]   self_id = 8'h05;
  logic              bus_we = 1'b0, bus_re = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              msg_valid, msg_ready = 1'b0;
  logic [7:0]        msg_vector;
  logic [2:0]        msg_mode;
  logic              msg_logical, msg_assert, msg_bcast, msg_skip_self;
  logic [1:0]        msg_shorthand;
  logic [ID_W-1:0]   msg_dest;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_cmd #(.ADDR_W(ADDR_W), .ID_W(ID_W)) dut (
    .clk(clk), .rst(rst), .self_id(self_id), .bus_we(bus_we),
    .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_logical(msg_logical),
    .msg_assert(msg_assert), .msg_shorthand(msg_shorthand),
    .msg_dest(msg_dest), .msg_bcast(msg_bcast), .msg_skip_self(msg_skip_self)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic take();
    @(negedge clk);
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 valid after reset", 32'(msg_valid), 32'd0);
    chk("R1 rdata after reset", bus_rdata, 32'd0);
    rd(0, d); chk("R1 low word", d, 32'd0);
    rd(1, d); chk("R1 high word", d, 32'd0);
    rd(2, d); chk("R1 status word", d, 32'd0);
  endtask

  task automatic t_high_only();
    logic [31:0] d;
    wr(1, 32'hAB00_00FF);
    chk("R2 no message on high write", 32'(msg_valid), 32'd0);
    rd(1, d); chk("R2 high readback", d, 32'hAB00_0000);
    chk("R2 still no message", 32'(msg_valid), 32'd0);
  endtask

  task automatic t_launch_fixed();
    logic [31:0] d;
    wr(0, 32'h0000_0830);
    chk("R3 valid", 32'(msg_valid), 32'd1);
    chk("R3 vector", 32'(msg_vector), 32'h30);
    chk("R3 mode", 32'(msg_mode), 32'd0);
    chk("R3 logical", 32'(msg_logical), 32'd1);
    chk("R3 assert", 32'(msg_assert), 32'd0);
    chk("R7 dest explicit", 32'(msg_dest), 32'hAB);
    chk("R7 bcast/skip", {30'd0, msg_bcast, msg_skip_self}, 32'd0);
    rd(0, d); chk("R4 busy bit set", d, 32'h0000_1830);
    repeat (3) @(negedge clk);
    chk("R5 held vector", 32'(msg_vector), 32'h30);
    chk("R5 held dest", 32'(msg_dest), 32'hAB);
    chk("R4 still valid", 32'(msg_valid), 32'd1);
    take();
    chk("R4 valid drops after accept", 32'(msg_valid), 32'd0);
    rd(0, d); chk("R4 busy bit clear", d, 32'h0000_0830);
  endtask

  task automatic t_busy_write();
    logic [31:0] d;
    wr(0, 32'h0000_0031);
    wr(0, 32'h0000_0040);
    chk("R6 vector unchanged", 32'(msg_vector), 32'h31);
    rd(2, d); chk("R6 error set", d, 32'd1);
    rd(0, d); chk("R6 stored low unchanged", d, 32'h0000_1031);
    rd(2, d); chk("R6 error sticky", d, 32'd1);
    wr(2, 32'd1);
    rd(2, d); chk("R6 error cleared", d, 32'd0);
    take();
    chk("R6 no second message", 32'(msg_valid), 32'd0);
  endtask

  task automatic t_shorthand();
    wr(0, 32'h0004_0032);
    chk("R8 dest self", 32'(msg_dest), 32'h05);
    chk("R8 bcast", 32'(msg_bcast), 32'd0);
    chk("R3 shorthand field", 32'(msg_shorthand), 32'd1);
    take();
    wr(0, 32'h0008_0033);
    chk("R9 all dest", 32'(msg_dest), 32'hFF);
    chk("R9 all flags", {30'd0, msg_bcast, msg_skip_self}, 32'd2);
    take();
    wr(0, 32'h000C_0031);
    chk("R9 others dest", 32'(msg_dest), 32'hFF);
    chk("R9 others flags", {30'd0, msg_bcast, msg_skip_self}, 32'd3);
    take();
  endtask

  task automatic t_init_startup();
    wr(0, 32'h0000_4500);
    chk("R10 init mode", 32'(msg_mode), 32'd5);
    chk("R10 init assert", 32'(msg_assert), 32'd1);
    chk("R10 init vector", 32'(msg_vector), 32'd0);
    chk("R7 init dest", 32'(msg_dest), 32'hAB);
    take();
    wr(0, 32'h0000_4608);
    chk("R10 startup mode", 32'(msg_mode), 32'd6);
    chk("R10 startup page", 32'(msg_vector), 32'h08);
    take();
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R11 reserved bits zero", d, 32'h000C_5FFF);
    take();
    rd(0, d); chk("R11 after accept", d, 32'h000C_4FFF);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_high_only();
    t_launch_fixed();
    t_busy_write();
    t_shorthand();
    t_init_startup();
    t_reserved();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule